// File: doc/BRIEF.md
# I2C Master Receive Acknowledge Sequencer

This block is the receive half of an I2C master controller. Once the address phase is over, it assembles incoming data bits into bytes and decides, for each byte, whether the master answers with ACK or NACK. It also decides when the pending STOP or repeated START goes out on the bus. Bit timing, address transmission and arbitration belong to other logic. Here, each data or acknowledge bit arrives as a one-cycle strobe, and the end of the address phase arrives as a one-cycle pulse.

Storage is one shift register plus one holding register. A completed byte moves into the holding register if that register is empty; if it is still full, the byte stays in the shift register. In that second case the block raises the transfer-finished flag and holds SCL low until software reads. A position control lets an acknowledge setting written now apply to the following byte instead of the current one. Together with the stall, this lets driver software run clean end-of-read sequences for one byte, two bytes and longer reads, and it can also terminate a read of zero length.

Control writes and holding-register reads share one simple register port. The control word has five bits: bit 0 is the acknowledge enable, bit 1 is the position control, bit 2 requests STOP, bit 3 requests repeated START, and bit 4 asks for the request to be issued at once.

Top module: `i2c_rx_ack_seq`

## Requirements
- R1: After reset, rxne, btf, scl_hold, rx_active, ack_slot, cond_stop, cond_start, cfg_ack_en and cfg_pos are all 0.
- R2: While a read is active, the first eight accepted strobes shift bit_in in MSB first. The ninth strobe is the acknowledge slot: ack_slot pulses for one cycle, and the byte enters the holding register if that register is empty, setting rxne.
- R3: With the position control at 0, ack_bit (1 = ACK, 0 = NACK) equals the acknowledge enable held in the cycle of the acknowledge slot.
- R4: With the position control at 1, the first byte after addr_done is acknowledged. Each later byte uses the acknowledge enable that was held at the previous byte's slot.
- R5: If a byte completes while rxne is 1, it stays in the shift register and btf and scl_hold go to 1. Until a read frees the holding register, bit strobes are ignored and the waiting byte is not altered.
- R6: rd_data shows the holding register. A dr_re pulse clears rxne, except when btf is 1: then the waiting byte moves to the holding register in the same cycle, btf clears and rxne stays 1.
- R7: The acknowledge enable and position control keep their written values until the next control write. A STOP or START request clears itself once issued and does not fire again.
- R8: A pending request is issued together with the next acknowledge slot. It is issued in the cycle after it becomes pending if btf is 1 or if bit 4 was set. Issuing pulses cond_stop or cond_start for one cycle, with STOP winning if both are requested, and ends the read (rx_active 0).
- R9: One-byte read: with enable 0, position 0 and the request written before addr_done, the byte gets NACK, and the condition pulses alongside that byte's acknowledge slot.
- R10: Two-byte read: with enable 0 and position 1 written before addr_done, byte 1 gets ACK and byte 2 gets NACK. A request written after btf rises is issued, and both bytes then read back in order.
- R11: N-byte read (N at least 3) with enable 1: bytes up to N-3 are read on rxne. Clearing the enable at btf, before reading byte N-2, makes only byte N NACKed. A request written at the next btf precedes two back-to-back reads.
- R12: Zero-length read: a request written with bit 4 set after addr_done pulses its condition within two cycles and ends the read with no byte clocked.
- R13: Bit strobes outside an active read produce no acknowledge slot and leave rxne unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per received bit or acknowledge slot |
| bit_in | input | 1 | SDA level sampled with bit_stb |
| addr_done | input | 1 | Pulse marking the end of the address phase; starts a read |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 5 | Control word: {now, start, stop, pos, ack_en} |
| dr_re | input | 1 | Holding register read strobe |
| rd_data | output | 8 | Holding register contents |
| rxne | output | 1 | Holding register contains an unread byte |
| btf | output | 1 | A second byte waits in the shift register |
| scl_hold | output | 1 | Keep SCL low (stall) |
| ack_slot | output | 1 | Pulse: acknowledge slot just taken |
| ack_bit | output | 1 | Acknowledge driven in that slot, 1 = ACK |
| cond_stop | output | 1 | Pulse: STOP issued |
| cond_start | output | 1 | Pulse: repeated START issued |
| rx_active | output | 1 | A read is in progress |
| cfg_ack_en | output | 1 | Current acknowledge enable |
| cfg_pos | output | 1 | Current position control |

## Verification
The bench goes after where the NACK lands. A design that misroutes the position control would acknowledge the last byte of a two-byte read or NACK the first, and one that samples the enable at the wrong time would NACK byte N-1 of a longer read. It also drives bit strobes into a stalled bus and checks that they are ignored: a design that keeps shifting during the stall would corrupt the waiting byte, and that shows up in the data read back. Finally, it checks when each condition appears and that a request fires only once. A design that issues too early, too late or twice changes the STOP and START pulse counts seen after each step.

// File: rtl/i2c_rx_pkg.sv
// Shared types for the I2C receive acknowledge sequencer.
package i2c_rx_pkg;
    localparam int CFG_W = 5;

    // Control word as written through the register port, MSB first.
    typedef struct packed {
        logic now;     // issue the request without waiting for a byte
        logic start;   // request repeated START
        logic stop;    // request STOP
        logic pos;     // acknowledge setting applies to the following byte
        logic ack;     // acknowledge enable
    } cfg_t;
endpackage

// File: rtl/i2c_rx_shifter.sv
// Bit assembler: counts accepted strobes, shifts data bits in MSB first
// and flags the acknowledge slot (the strobe after the last data bit).
// Assumes the caller drops en while stalled or idle; restart realigns the
// counter at the start of each read.
module i2c_rx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic              bit_stb,
    input  logic              bit_in,
    output logic              slot,
    output logic [DATA_W-1:0] shreg
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take = en & bit_stb;
    assign slot = take & (cnt == LAST);

    // Bit position counter: wraps after the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
        end
    end

    // Shift register: loads data bits only, keeps its byte otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (take && cnt != LAST) begin
            shreg <= {shreg[DATA_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/i2c_rx_hold.sv
// Holding register and its occupancy flags. A completed byte goes to the
// holding register when free (or freed by a read in the same cycle),
// otherwise it is marked as waiting in the shift register.
// Assumes slot never coincides with a waiting byte (the bus is stalled).
module i2c_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              dr_re,
    output logic [DATA_W-1:0] dr,
    output logic              dr_full,
    output logic              sh_full
);
    logic rd;

    assign rd = dr_re & dr_full;

    // Holding register and the two occupancy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr      <= '0;
            dr_full <= 1'b0;
            sh_full <= 1'b0;
        end else if (rd && sh_full) begin
            dr      <= byte_in;
            sh_full <= 1'b0;
        end else if (slot) begin
            if (!dr_full || rd) begin
                dr      <= byte_in;
                dr_full <= 1'b1;
            end else begin
                sh_full <= 1'b1;
            end
        end else if (rd) begin
            dr_full <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_rx_ctrl.sv
// Acknowledge and bus-condition control: holds the enable and position
// settings, the one-byte-ahead acknowledge latch, the pending STOP/START
// requests and the read-active state; drives registered output pulses.
// Assumes slot and btf come from the shifter and holding unit.
module i2c_rx_ctrl
    import i2c_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_done,
    input  logic cfg_we,
    input  cfg_t cfg_in,
    input  logic slot,
    input  logic btf,
    output logic ack_slot_q,
    output logic ack_bit_q,
    output logic cond_stop_q,
    output logic cond_start_q,
    output logic active,
    output logic ack_en,
    output logic pos
);
    logic cur_ack;
    logic stop_req;
    logic start_req;
    logic now_req;
    logic ack_value;
    logic issue;

    assign ack_value = pos ? cur_ack : ack_en;
    assign issue     = (stop_req | start_req) & (slot | btf | now_req);

    // Software settings: retained until the next control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en <= 1'b0;
            pos    <= 1'b0;
        end else if (cfg_we) begin
            ack_en <= cfg_in.ack;
            pos    <= cfg_in.pos;
        end
    end

    // Pending requests: cleared on issue, set by a write (write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_req  <= 1'b0;
            start_req <= 1'b0;
            now_req   <= 1'b0;
        end else begin
            if (issue) begin
                stop_req  <= 1'b0;
                start_req <= 1'b0;
                now_req   <= 1'b0;
            end
            if (cfg_we) begin
                if (cfg_in.stop)  stop_req  <= 1'b1;
                if (cfg_in.start) start_req <= 1'b1;
                if (cfg_in.now && (cfg_in.stop || cfg_in.start)) now_req <= 1'b1;
            end
        end
    end

    // Acknowledge for the following byte when the position control is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ack <= 1'b1;
        end else if (addr_done) begin
            cur_ack <= 1'b1;
        end else if (slot) begin
            cur_ack <= ack_en;
        end
    end

    // Read-active state: opened by the address phase, closed by a condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (issue) begin
            active <= 1'b0;
        end else if (addr_done) begin
            active <= 1'b1;
        end
    end

    // Registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_slot_q   <= 1'b0;
            ack_bit_q    <= 1'b0;
            cond_stop_q  <= 1'b0;
            cond_start_q <= 1'b0;
        end else begin
            ack_slot_q   <= slot;
            ack_bit_q    <= slot & ack_value;
            cond_stop_q  <= issue & stop_req;
            cond_start_q <= issue & ~stop_req & start_req;
        end
    end
endmodule

// File: rtl/i2c_rx_ack_seq.sv
// Top of the I2C master receive acknowledge sequencer. Connects the bit
// assembler, the holding register and the acknowledge/condition control;
// the bus stalls (scl_hold) while a byte waits behind an unread one.
// Assumes bit_stb never arrives faster than one per cycle.
module i2c_rx_ack_seq
    import i2c_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              addr_done,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              dr_re,
    output logic [DATA_W-1:0] rd_data,
    output logic              rxne,
    output logic              btf,
    output logic              scl_hold,
    output logic              ack_slot,
    output logic              ack_bit,
    output logic              cond_stop,
    output logic              cond_start,
    output logic              rx_active,
    output logic              cfg_ack_en,
    output logic              cfg_pos
);
    logic              slot;
    logic [DATA_W-1:0] shreg;
    logic              sh_en;
    cfg_t              cfg_in;

    assign cfg_in   = cfg_t'(cfg_wdata);
    assign sh_en    = rx_active & ~btf;
    assign scl_hold = btf;

    i2c_rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sh_en),
        .restart (addr_done),
        .bit_stb (bit_stb),
        .bit_in  (bit_in),
        .slot    (slot),
        .shreg   (shreg)
    );

    i2c_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .byte_in (shreg),
        .dr_re   (dr_re),
        .dr      (rd_data),
        .dr_full (rxne),
        .sh_full (btf)
    );

    i2c_rx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_done    (addr_done),
        .cfg_we       (cfg_we),
        .cfg_in       (cfg_in),
        .slot         (slot),
        .btf          (btf),
        .ack_slot_q   (ack_slot),
        .ack_bit_q    (ack_bit),
        .cond_stop_q  (cond_stop),
        .cond_start_q (cond_start),
        .active       (rx_active),
        .ack_en       (cfg_ack_en),
        .pos          (cfg_pos)
    );
endmodule

// File: rtl/i2c_rx_ack_seq_chk.sv
// Property checker for the receive acknowledge sequencer, bound to the top.
module i2c_rx_ack_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic dr_re,
    input logic rxne,
    input logic btf,
    input logic ack_slot,
    input logic cond_stop,
    input logic cond_start,
    input logic rx_active,
    input logic cfg_ack_en
);
    p_btf_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btf |-> rxne);

    p_stall_blocks_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btf |=> !ack_slot);

    p_btf_rise_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(btf) |-> ack_slot);

    p_rxne_fall_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxne) |-> $past(dr_re));

    p_ack_en_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_ack_en));

    p_single_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond_stop && cond_start));

    p_cond_ends_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_stop || cond_start) |-> !rx_active);

    p_idle_no_slot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> !ack_slot);
endmodule

bind i2c_rx_ack_seq i2c_rx_ack_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .dr_re      (dr_re),
    .rxne       (rxne),
    .btf        (btf),
    .ack_slot   (ack_slot),
    .cond_stop  (cond_stop),
    .cond_start (cond_start),
    .rx_active  (rx_active),
    .cfg_ack_en (cfg_ack_en)
);

// File: tb/i2c_rx_ack_seq_tb.sv
module i2c_rx_ack_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_in = 1'b0;
    logic       addr_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       dr_re = 1'b0;
    logic [7:0] rd_data;
    logic       rxne, btf, scl_hold, ack_slot, ack_bit;
    logic       cond_stop, cond_start, rx_active, cfg_ack_en, cfg_pos;

    int checks = 0;
    int fails = 0;
    int n_stop = 0;
    int n_start = 0;
    int snap_stop = 0;
    int snap_start = 0;

    always #5 clk = ~clk;

    i2c_rx_ack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .addr_done(addr_done), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dr_re(dr_re), .rd_data(rd_data), .rxne(rxne), .btf(btf),
        .scl_hold(scl_hold), .ack_slot(ack_slot), .ack_bit(ack_bit),
        .cond_stop(cond_stop), .cond_start(cond_start), .rx_active(rx_active),
        .cfg_ack_en(cfg_ack_en), .cfg_pos(cfg_pos)
    );

    // Count condition pulses away from the active edge.
    always @(negedge clk) begin
        if (cond_stop)  n_stop++;
        if (cond_start) n_start++;
    end

    // Read transactions: {length, first data byte, 1 = repeated START}.
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        {4'd0, 8'h00, 1'b0}, {4'd0, 8'h00, 1'b1},
        {4'd1, 8'hA5, 1'b0}, {4'd1, 8'h3C, 1'b1},
        {4'd2, 8'h81, 1'b0}, {4'd2, 8'h7E, 1'b1},
        {4'd3, 8'h10, 0},    {4'd4, 8'hF0, 1'b1},
        {4'd5, 8'h55, 1'b0}, {4'd6, 8'hC3, 1'b0}
    };

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic snap();
        snap_stop  = n_stop;
        snap_start = n_start;
    endtask

    task automatic cond_chk(input string req, input int ds, input int dt);
        chk_eq({req, " stop count"},  n_stop - snap_stop, ds);
        chk_eq({req, " start count"}, n_start - snap_start, dt);
    endtask

    task automatic cfg_write(input logic [4:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic addr_pulse();
        @(negedge clk); addr_done = 1'b1;
        @(negedge clk); addr_done = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        @(negedge clk); d = rd_data; dr_re = 1'b1;
        @(negedge clk); dr_re = 1'b0;
    endtask

    // Eight data bits MSB first then the acknowledge slot; samples the slot.
    task automatic send_byte(input logic [7:0] b, output logic sl, output logic ab);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); bit_stb = 1'b1; bit_in = (i < 8) ? b[7-i] : 1'b1;
            @(negedge clk); bit_stb = 1'b0;
        end
        sl = ack_slot;
        ab = ack_bit;
    endtask

    function automatic logic [7:0] dat(input logic [7:0] base, input int k);
        return base + 8'(k * 17);
    endfunction

    task automatic do_read(input int len, input logic [7:0] base, input logic rs);
        logic sl, ab;
        logic [7:0] d;
        if (len == 0) begin
            addr_pulse();
            snap();
            cfg_write({1'b1, rs, !rs, 1'b0, 1'b0});
            repeat (2) @(negedge clk);
            cond_chk("R12 zero-length", int'(!rs), int'(rs));
            chk_eq("R12 read ended", rx_active, 0);
        end else if (len == 1) begin
            cfg_write({1'b0, rs, !rs, 1'b0, 1'b0});
            addr_pulse();
            snap();
            send_byte(base, sl, ab);
            chk_eq("R9 slot taken", sl, 1);
            chk_eq("R9 single byte NACK", ab, 0);
            @(negedge clk);
            cond_chk("R9 condition with byte", int'(!rs), int'(rs));
            chk_eq("R9 rxne", rxne, 1);
            rd_byte(d);
            chk_eq("R2 R9 data", d, base);
            chk_eq("R8 read ended", rx_active, 0);
        end else if (len == 2) begin
            cfg_write(5'b00010);
            addr_pulse();
            send_byte(dat(base, 0), sl, ab);
            chk_eq("R4 R10 first byte ACK", ab, 1);
            send_byte(dat(base, 1), sl, ab);
            chk_eq("R4 R10 second byte NACK", ab, 0);
            chk_eq("R10 btf", btf, 1);
            snap();
            cfg_write({1'b0, rs, !rs, 1'b1, 1'b0});
            repeat (2) @(negedge clk);
            cond_chk("R8 R10 condition on stall", int'(!rs), int'(rs));
            rd_byte(d);
            chk_eq("R10 byte 1", d, dat(base, 0));
            chk_eq("R6 btf cleared by read", btf, 0);
            chk_eq("R6 rxne kept", rxne, 1);
            rd_byte(d);
            chk_eq("R10 byte 2", d, dat(base, 1));
            chk_eq("R6 rxne cleared", rxne, 0);
            cfg_write(5'b00000);
        end else begin
            cfg_write(5'b00001);
            addr_pulse();
            for (int k = 0; k < len - 3; k++) begin
                send_byte(dat(base, k), sl, ab);
                chk_eq("R3 R11 early ACK", ab, 1);
                rd_byte(d);
                chk_eq("R2 R11 early data", d, dat(base, k));
            end
            chk_eq("R7 enable retained", cfg_ack_en, 1);
            send_byte(dat(base, len - 3), sl, ab);
            chk_eq("R3 R11 byte N-2 ACK", ab, 1);
            send_byte(dat(base, len - 2), sl, ab);
            chk_eq("R3 R11 byte N-1 ACK", ab, 1);
            chk_eq("R5 btf raised", btf, 1);
            chk_eq("R5 scl held", scl_hold, 1);
            cfg_write(5'b00000);
            rd_byte(d);
            chk_eq("R11 byte N-2", d, dat(base, len - 3));
            chk_eq("R6 btf cleared", btf, 0);
            send_byte(dat(base, len - 1), sl, ab);
            chk_eq("R3 R11 last byte NACK", ab, 0);
            chk_eq("R11 btf at end", btf, 1);
            snap();
            cfg_write({1'b0, rs, !rs, 1'b0, 1'b0});
            repeat (2) @(negedge clk);
            cond_chk("R11 condition", int'(!rs), int'(rs));
            rd_byte(d);
            chk_eq("R11 byte N-1", d, dat(base, len - 2));
            rd_byte(d);
            chk_eq("R11 byte N", d, dat(base, len - 1));
            chk_eq("R11 rxne empty", rxne, 0);
            chk_eq("R8 read ended", rx_active, 0);
        end
    endtask

    initial begin
        logic sl, ab;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 rxne", rxne, 0);
        chk_eq("R1 btf", btf, 0);
        chk_eq("R1 scl_hold", scl_hold, 0);
        chk_eq("R1 rx_active", rx_active, 0);
        chk_eq("R1 cfg", {cfg_ack_en, cfg_pos}, 0);
        chk_eq("R1 pulses", {ack_slot, cond_stop, cond_start}, 0);

        // R13: strobes while idle.
        send_byte(8'hA5, sl, ab);
        chk_eq("R13 no slot when idle", sl, 0);
        chk_eq("R13 rxne unchanged", rxne, 0);

        for (int v = 0; v < NV; v++) begin
            do_read(int'(VEC[v][12:9]), VEC[v][8:1], VEC[v][0]);
        end

        // R8: STOP wins over START.
        snap();
        cfg_write(5'b11100);
        repeat (2) @(negedge clk);
        cond_chk("R8 stop wins", 1, 0);

        // R7: an issued request does not fire again.
        cfg_write(5'b00000);
        addr_pulse();
        snap();
        send_byte(8'h3C, sl, ab);
        @(negedge clk);
        cond_chk("R7 request cleared", 0, 0);
        chk_eq("R7 read still active", rx_active, 1);
        rd_byte(d);
        snap();
        cfg_write(5'b10100);
        repeat (2) @(negedge clk);
        cond_chk("R7 fresh request", 1, 0);

        // R5: strobes during the stall are ignored.
        cfg_write(5'b00010);
        addr_pulse();
        send_byte(8'h11, sl, ab);
        send_byte(8'h22, sl, ab);
        send_byte(8'hFF, sl, ab);
        chk_eq("R5 no slot while stalled", sl, 0);
        chk_eq("R5 still stalled", btf, 1);
        cfg_write(5'b00110);
        repeat (2) @(negedge clk);
        rd_byte(d);
        chk_eq("R5 held byte", d, 8'h11);
        rd_byte(d);
        chk_eq("R5 waiting byte intact", d, 8'h22);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule